// File: doc/BRIEF.md
# CompactFlash Host Bus Glue

This block joins an asynchronous processor static-memory bus to a CompactFlash card that runs either in PC Card memory mode or in PC Card I/O mode. The processor's one read/write strobe pair is routed combinationally onto the card's memory strobes (output enable and write enable) or onto its I/O strobes (I/O read and I/O write). A one-bit mode register picks the route, and the pair that is not picked stays inactive. The processor chip select, a bus-width setting and address bit 0 drive the two card-enable lines, which select a byte lane or the full 16-bit word.

The two card-detect pins are first synchronized into the clock domain and then filtered. The card counts as present only after both pins have been low for a programmable number of consecutive cycles. While no card is present, every strobe, enable, address and buffer-enable output toward the card is held inactive, and the wait line to the processor is released. The split data buffer has one enable for each direction. The processor's read/not-write line sets the direction, and the buffer is enabled only during an active chip select.

The card's wait request is passed back to the processor, which stretches the bus cycle. The card's ready/busy line is made available as a status output. The card reset is the inverse of the active-low system reset.

Top module: `cf_host_glue`

## Requirements
- R1: With the mode bit at 0 (memory mode), a present card and `cpu_cs_n` low, `card_oe_n` follows `cpu_rd_n` and `card_we_n` follows `cpu_wr_n`. Both `card_iord_n` and `card_iowr_n` stay high.
- R2: With the mode bit at 1 (I/O mode), a present card and `cpu_cs_n` low, `card_iord_n` follows `cpu_rd_n` and `card_iowr_n` follows `cpu_wr_n`. Both `card_oe_n` and `card_we_n` stay high.
- R3: `card_present` is 1 only when both `card_cd1_n` and `card_cd2_n` are low, after a two-flop synchronizer and DEB_CYCLES consecutive cycles of the new state. An input change driven before clock edge 0 shows on `card_present` after edge DEB_CYCLES+1. Shorter pulses are ignored.
- R4: While `card_present` is 0, all of the following hold whatever the processor inputs are:
  - all four card strobes and both card enables are high;
  - `card_addr` is 0;
  - both data enables are 0 and both data outputs are 0;
  - `cpu_wait_n` is 1;
  - `card_ready` is 0.
- R5: While the card is present and `cpu_cs_n` is low, `card_addr` equals `cpu_addr`. With `cpu_rnw`=0, `card_dq_oe`=1 and `card_dq_out`=`cpu_wdata`. With `cpu_rnw`=1, `host_dq_oe`=1 and `host_dq_out`=`card_rdata`. With `cpu_cs_n` high, both enables are 0.
- R6: The card enables {`card_ce1_n`,`card_ce2_n`} follow these rules:
  - `cpu_cs_n` high gives 11.
  - `cpu_bus8`=0 gives 00 (word access), whatever `cpu_addr[0]` is.
  - `cpu_bus8`=1 with `cpu_addr[0]`=0 gives 01 (low byte).
  - `cpu_bus8`=1 with `cpu_addr[0]`=1 gives 10 (odd byte).
- R7: `cpu_wait_n` is low only when the card is present, `cpu_cs_n` is low and `card_wait_n` is low.
- R8: `card_reset` is the inverse of `rst_n` and does not depend on card presence.
- R9: The mode bit resets to 0. It takes `mode_wdata` on a clock edge with `mode_we` high and holds its value otherwise.
- R10: While the card is present, `card_ready` equals `card_rdy` (1 means ready, 0 means busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the detect filter and the mode register |
| rst_n | input | 1 | Active-low system reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 1 | New mode value: 0 memory, 1 I/O |
| cpu_cs_n | input | 1 | Processor card chip select, active low |
| cpu_rnw | input | 1 | Processor direction: 1 read, 0 write |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_bus8 | input | 1 | Bus configured for 8-bit width |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Write data from the processor |
| host_dq_out | output | DATA_W | Read data toward the processor |
| host_dq_oe | output | 1 | Drive enable toward the processor |
| cpu_wait_n | output | 1 | Wait request to the processor, active low |
| card_cd1_n | input | 1 | Card detect pin 1, active low |
| card_cd2_n | input | 1 | Card detect pin 2, active low |
| card_wait_n | input | 1 | Card wait request, active low |
| card_rdy | input | 1 | Card ready/busy line |
| card_rdata | input | DATA_W | Read data from the card |
| card_addr | output | ADDR_W | Card address |
| card_dq_out | output | DATA_W | Write data toward the card |
| card_dq_oe | output | 1 | Drive enable toward the card |
| card_oe_n | output | 1 | Card memory output enable |
| card_we_n | output | 1 | Card memory write enable |
| card_iord_n | output | 1 | Card I/O read strobe |
| card_iowr_n | output | 1 | Card I/O write strobe |
| card_ce1_n | output | 1 | Card enable, low/even byte lane |
| card_ce2_n | output | 1 | Card enable, high/odd byte lane |
| card_reset | output | 1 | Card reset, active high |
| card_present | output | 1 | Filtered card-present flag |
| card_ready | output | 1 | Card ready status |

## Verification
The only state in the block is the mode bit and the detect filter, so any internal fault shows up on the strobe pins in the same cycle as the access. A wrong mode bit turns a memory access into an I/O access, and the bench sees the wrong strobe pair move low. A debounce counter that miscounts moves the `card_present` edge off its exact cycle, DEB_CYCLES+1 edges after the pin change. A filter that lets glitches through shows as a card that appears or disappears. Either fault then opens or closes every gated card output on the following cycle.

// File: rtl/cf_glue_pkg.sv
package cf_glue_pkg;

  typedef enum logic {
    MODE_MEM = 1'b0,
    MODE_IO  = 1'b1
  } cf_mode_e;

  typedef struct packed {
    logic oe_n;
    logic we_n;
    logic iord_n;
    logic iowr_n;
  } cf_strobe_t;

  localparam cf_strobe_t STROBE_IDLE = '{oe_n: 1'b1, we_n: 1'b1, iord_n: 1'b1, iowr_n: 1'b1};

  // Route the processor strobe pair onto one card strobe pair.
  function automatic cf_strobe_t f_steer(cf_mode_e mode, logic act, logic rd_n, logic wr_n);
    cf_strobe_t s;
    s = STROBE_IDLE;
    if (act) begin
      if (mode == MODE_IO) begin
        s.iord_n = rd_n;
        s.iowr_n = wr_n;
      end else begin
        s.oe_n = rd_n;
        s.we_n = wr_n;
      end
    end
    return s;
  endfunction

  // Byte lane enables, returned as {ce1_n, ce2_n}.
  function automatic logic [1:0] f_lanes(logic act, logic bus8, logic a0);
    logic [1:0] ce;
    if (!act)       ce = 2'b11;
    else if (!bus8) ce = 2'b00;
    else if (a0)    ce = 2'b10;
    else            ce = 2'b01;
    return ce;
  endfunction

endpackage

// File: rtl/cf_detect_filter.sv
module cf_detect_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd1_n,
  input  logic cd2_n,
  output logic present,
  output logic cand
);
  localparam int CNT_W = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [1:0] sync1_q, sync2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 2'b11;
      sync2_q <= 2'b11;
    end else begin
      sync1_q <= {cd2_n, cd1_n};
      sync2_q <= sync1_q;
    end
  end

  assign cand = (sync2_q == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      present <= 1'b0;
    end else if (cand == present) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      present <= cand;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cf_mode_reg.sv
module cf_mode_reg
  import cf_glue_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic     wdata,
  output cf_mode_e mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode <= MODE_MEM;
    else if (we) mode <= cf_mode_e'(wdata);
  end
endmodule

// File: rtl/cf_bus_steer.sv
module cf_bus_steer
  import cf_glue_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  cf_mode_e          mode,
  input  logic              present,
  input  logic              cs_n,
  input  logic              rnw,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bus8,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic              card_wait_n,
  input  logic              card_rdy,
  output cf_strobe_t        strobes,
  output logic [1:0]        ce_n,
  output logic [ADDR_W-1:0] card_addr,
  output logic [DATA_W-1:0] card_dq_out,
  output logic              card_dq_oe,
  output logic [DATA_W-1:0] host_dq_out,
  output logic              host_dq_oe,
  output logic              wait_n,
  output logic              ready
);
  logic act;
  assign act = present & ~cs_n;

  always_comb begin
    strobes     = f_steer(mode, act, rd_n, wr_n);
    ce_n        = f_lanes(act, bus8, addr[0]);
    card_addr   = present ? addr : '0;
    card_dq_oe  = act & ~rnw;
    host_dq_oe  = act & rnw;
    card_dq_out = card_dq_oe ? wdata : '0;
    host_dq_out = host_dq_oe ? rdata : '0;
    wait_n      = ~(act & ~card_wait_n);
    ready       = present & card_rdy;
  end
endmodule

// File: rtl/cf_host_glue.sv
module cf_host_glue
  import cf_glue_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 16,
  parameter int DEB_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_wdata,
  input  logic              cpu_cs_n,
  input  logic              cpu_rnw,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic              cpu_bus8,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] host_dq_out,
  output logic              host_dq_oe,
  output logic              cpu_wait_n,
  input  logic              card_cd1_n,
  input  logic              card_cd2_n,
  input  logic              card_wait_n,
  input  logic              card_rdy,
  input  logic [DATA_W-1:0] card_rdata,
  output logic [ADDR_W-1:0] card_addr,
  output logic [DATA_W-1:0] card_dq_out,
  output logic              card_dq_oe,
  output logic              card_oe_n,
  output logic              card_we_n,
  output logic              card_iord_n,
  output logic              card_iowr_n,
  output logic              card_ce1_n,
  output logic              card_ce2_n,
  output logic              card_reset,
  output logic              card_present,
  output logic              card_ready
);
  cf_mode_e   mode_q;
  logic       mode_io;
  logic       det_cand;
  cf_strobe_t strobes;
  logic [1:0] ce_n;

  assign mode_io = (mode_q == MODE_IO);

  cf_detect_filter #(.DEB_CYCLES(DEB_CYCLES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .cd1_n   (card_cd1_n),
    .cd2_n   (card_cd2_n),
    .present (card_present),
    .cand    (det_cand)
  );

  cf_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mode_we),
    .wdata (mode_wdata),
    .mode  (mode_q)
  );

  cf_bus_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
    .mode        (mode_q),
    .present     (card_present),
    .cs_n        (cpu_cs_n),
    .rnw         (cpu_rnw),
    .rd_n        (cpu_rd_n),
    .wr_n        (cpu_wr_n),
    .bus8        (cpu_bus8),
    .addr        (cpu_addr),
    .wdata       (cpu_wdata),
    .rdata       (card_rdata),
    .card_wait_n (card_wait_n),
    .card_rdy    (card_rdy),
    .strobes     (strobes),
    .ce_n        (ce_n),
    .card_addr   (card_addr),
    .card_dq_out (card_dq_out),
    .card_dq_oe  (card_dq_oe),
    .host_dq_out (host_dq_out),
    .host_dq_oe  (host_dq_oe),
    .wait_n      (cpu_wait_n),
    .ready       (card_ready)
  );

  assign card_oe_n   = strobes.oe_n;
  assign card_we_n   = strobes.we_n;
  assign card_iord_n = strobes.iord_n;
  assign card_iowr_n = strobes.iowr_n;
  assign card_ce1_n  = ce_n[1];
  assign card_ce2_n  = ce_n[0];
  assign card_reset  = ~rst_n;

endmodule

// File: rtl/cf_glue_chk.sv
module cf_glue_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic              mode_wdata,
  input logic              mode_io,
  input logic              det_cand,
  input logic              cpu_cs_n,
  input logic              cpu_bus8,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              card_wait_n,
  input logic              cpu_wait_n,
  input logic              card_present,
  input logic              card_oe_n,
  input logic              card_we_n,
  input logic              card_iord_n,
  input logic              card_iowr_n,
  input logic              card_ce1_n,
  input logic              card_ce2_n,
  input logic              card_dq_oe,
  input logic              host_dq_oe,
  input logic [ADDR_W-1:0] card_addr
);
  // R1 / R2: the memory and I/O strobe pairs never move low together
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_oe_n || !card_we_n) |-> (card_iord_n && card_iowr_n));
  p_io_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_iord_n || !card_iowr_n) |-> (mode_io && card_oe_n && card_we_n));

  // R3: a change of the present flag follows the synchronized candidate
  p_debounce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_present != $past(card_present)) |-> ($past(det_cand) == card_present));

  // R4: nothing reaches the card while absent
  p_absent_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present |-> (card_oe_n && card_we_n && card_iord_n && card_iowr_n &&
                       card_ce1_n && card_ce2_n && !card_dq_oe && !host_dq_oe &&
                       cpu_wait_n && (card_addr == '0)));

  // R5: the two buffer directions are never enabled together
  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_dq_oe && host_dq_oe));

  // R6: the word lane needs a 16-bit bus, the odd lane needs an odd address
  p_word_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_ce1_n && !card_ce2_n) |-> !cpu_bus8);
  p_odd_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_ce1_n && !card_ce2_n) |-> (cpu_bus8 && cpu_addr[0]));

  // R7: wait to the processor only for a selected card asking for it
  p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wait_n |-> (card_present && !cpu_cs_n && !card_wait_n));

  // R9: mode register update and hold
  p_mode_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_io == $past(mode_wdata)));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_io));
endmodule

bind cf_host_glue cf_glue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_we      (mode_we),
  .mode_wdata   (mode_wdata),
  .mode_io      (mode_io),
  .det_cand     (det_cand),
  .cpu_cs_n     (cpu_cs_n),
  .cpu_bus8     (cpu_bus8),
  .cpu_addr     (cpu_addr),
  .card_wait_n  (card_wait_n),
  .cpu_wait_n   (cpu_wait_n),
  .card_present (card_present),
  .card_oe_n    (card_oe_n),
  .card_we_n    (card_we_n),
  .card_iord_n  (card_iord_n),
  .card_iowr_n  (card_iowr_n),
  .card_ce1_n   (card_ce1_n),
  .card_ce2_n   (card_ce2_n),
  .card_dq_oe   (card_dq_oe),
  .host_dq_oe   (host_dq_oe),
  .card_addr    (card_addr)
);

// File: tb/cf_host_glue_tb.sv
module cf_host_glue_tb;
  localparam int AW  = 11;
  localparam int DW  = 16;
  localparam int DEB = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, mode_we, mode_wdata, cpu_cs_n, cpu_rnw, cpu_rd_n, cpu_wr_n, cpu_bus8;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, card_rdata, host_dq_out, card_dq_out;
  logic host_dq_oe, cpu_wait_n, card_cd1_n, card_cd2_n, card_wait_n, card_rdy;
  logic [AW-1:0] card_addr;
  logic card_dq_oe, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic card_ce1_n, card_ce2_n, card_reset, card_present, card_ready;

  cf_host_glue #(.ADDR_W(AW), .DATA_W(DW), .DEB_CYCLES(DEB)) u_dut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every card-side output at its inactive level (R4).
  task automatic chk_idle(input string tag);
    chk(tag, {card_oe_n, card_we_n, card_iord_n, card_iowr_n, card_ce1_n, card_ce2_n}, 6'b111111);
    chk(tag, {card_dq_oe, host_dq_oe, cpu_wait_n, card_ready}, 4'b0010);
    chk(tag, {card_addr, card_dq_out, host_dq_out}, '0);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {mode, cs_n, rnw, rd_n, wr_n, bus8, a0, oe_n, we_n, iord_n, iowr_n, ce1_n, ce2_n}
  localparam logic [12:0] VEC [10] = '{
    13'b0_0_1_0_1_0_0_0111_00,  // R1 memory read, word
    13'b0_0_0_1_0_0_0_1011_00,  // R1 memory write, word
    13'b1_0_1_0_1_0_0_1101_00,  // R2 I/O read, word
    13'b1_0_0_1_0_0_0_1110_00,  // R2 I/O write, word
    13'b0_0_1_0_1_1_0_0111_01,  // R6 8-bit even byte
    13'b0_0_1_0_1_1_1_0111_10,  // R6 8-bit odd byte
    13'b1_0_0_1_0_1_1_1110_10,  // R6 I/O odd byte write
    13'b0_1_1_0_1_0_0_1111_11,  // R6 chip select off, memory mode
    13'b0_0_1_0_1_0_1_0111_00,  // R6 odd address on 16-bit bus
    13'b1_1_0_1_0_0_0_1111_11   // R6 chip select off, I/O mode
  };

  initial begin
    rst_n = 1'b0; mode_we = 1'b0; mode_wdata = 1'b0;
    cpu_cs_n = 1'b0; cpu_rnw = 1'b1; cpu_rd_n = 1'b0; cpu_wr_n = 1'b1; cpu_bus8 = 1'b0;
    cpu_addr = 11'h5A5; cpu_wdata = 16'hBEEF; card_rdata = 16'h1234;
    card_cd1_n = 1'b1; card_cd2_n = 1'b1; card_wait_n = 1'b0; card_rdy = 1'b1;
    wait_neg(3);
    chk("R8 reset drives card reset", card_reset, 1'b1);
    chk("R3 absent in reset", card_present, 1'b0);
    chk_idle("R4 idle in reset");
    rst_n = 1'b1;
    wait_neg(1);
    chk("R8 card reset released", card_reset, 1'b0);

    // R3: a single low detect pin is not a card
    card_cd1_n = 1'b0;
    wait_neg(DEB + 6);
    chk("R3 one pin low", card_present, 1'b0);
    chk_idle("R4 absent with access driven");

    // R3: exact insertion latency
    card_cd2_n = 1'b0;
    wait_neg(DEB + 1);
    chk("R3 not yet present", card_present, 1'b0);
    wait_neg(1);
    chk("R3 present after filter", card_present, 1'b1);

    // R3: a pulse shorter than the filter is ignored
    card_cd2_n = 1'b1;
    wait_neg(DEB - 1);
    card_cd2_n = 1'b0;
    wait_neg(DEB + 4);
    chk("R3 glitch rejected", card_present, 1'b1);

    // Table walk: R1 R2 R6 plus data path R5
    for (int i = 0; i < 10; i++) begin
      logic [12:0] v;
      v = VEC[i];
      mode_we = 1'b1; mode_wdata = v[12];
      wait_neg(1);
      mode_we = 1'b0;
      cpu_cs_n = v[11]; cpu_rnw = v[10]; cpu_rd_n = v[9]; cpu_wr_n = v[8];
      cpu_bus8 = v[7]; cpu_addr = {10'h2C3, v[6]};
      cpu_wdata = 16'hA000 + 16'(i); card_rdata = 16'h0F00 + 16'(i);
      #1;
      chk($sformatf("R1/R2 strobes vec %0d", i),
          {card_oe_n, card_we_n, card_iord_n, card_iowr_n}, v[5:2]);
      chk($sformatf("R6 lanes vec %0d", i), {card_ce1_n, card_ce2_n}, v[1:0]);
      chk($sformatf("R5 enables vec %0d", i), {card_dq_oe, host_dq_oe},
          {~v[11] & ~v[10], ~v[11] & v[10]});
      chk($sformatf("R5 addr vec %0d", i), card_addr, {10'h2C3, v[6]});
      if (!v[11] && !v[10])
        chk($sformatf("R5 write data vec %0d", i), card_dq_out, 16'hA000 + 16'(i));
      if (!v[11] && v[10])
        chk($sformatf("R5 read data vec %0d", i), host_dq_out, 16'h0F00 + 16'(i));
    end

    // R9: mode held while the write strobe is low
    wait_neg(1);
    cpu_cs_n = 1'b0; cpu_rd_n = 1'b0; cpu_wr_n = 1'b1; cpu_rnw = 1'b1;
    mode_we = 1'b0; mode_wdata = 1'b0;
    wait_neg(2);
    chk("R9 mode held at I/O", {card_oe_n, card_iord_n}, 2'b10);

    // R7 wait forwarding, R10 ready status
    card_wait_n = 1'b0; #1;
    chk("R7 wait forwarded", cpu_wait_n, 1'b0);
    card_wait_n = 1'b1; #1;
    chk("R7 wait released", cpu_wait_n, 1'b1);
    card_wait_n = 1'b0; cpu_cs_n = 1'b1; #1;
    chk("R7 no wait without select", cpu_wait_n, 1'b1);
    card_rdy = 1'b0; #1;
    chk("R10 busy", card_ready, 1'b0);
    card_rdy = 1'b1; #1;
    chk("R10 ready", card_ready, 1'b1);

    // R3/R4: removal closes the path after the filter delay
    cpu_cs_n = 1'b0;
    wait_neg(1);
    card_cd1_n = 1'b1;
    wait_neg(DEB + 1);
    chk("R3 still present before filter", card_present, 1'b1);
    wait_neg(1);
    chk("R3 removal seen", card_present, 1'b0);
    chk_idle("R4 idle after removal");

    // R9: reset clears the mode back to memory
    rst_n = 1'b0;
    wait_neg(1);
    chk("R8 reset reasserted", card_reset, 1'b1);
    rst_n = 1'b1; card_cd1_n = 1'b0; card_cd2_n = 1'b0;
    cpu_rnw = 1'b1; cpu_rd_n = 1'b0; cpu_wr_n = 1'b1;
    wait_neg(DEB + 3);
    chk("R9 mode reset to memory", {card_oe_n, card_iord_n}, 2'b01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule